// File: doc/BRIEF.md
# Decode-to-Display Frame Reorder Controller

This controller sits between a video frame decoder and the display path. It manages three frame-buffer slots. Frames arrive in decoding order, and the controller releases them for display in display order. Before each frame is decoded, the decoder shows the controller the frame's picture type. The controller then answers with the slot that the frame must be written into. When decoding finishes, the decoder pulses a decode-done strobe, together with an end-of-sequence flag. One cycle later the controller pulses a display-release strobe, carrying the index of the slot to show.

Two slots hold the two most recent reference frames (intra or predicted). One holds the older reference and one the newer. A new reference always overwrites the older one, and the two roles then swap, so both references stay intact for bidirectional prediction. The third slot is reserved for bidirectional (B) frames. A B frame is shown as soon as it is decoded. A reference frame is held back and shown only when the next reference frame arrives or the sequence ends. At the end of a sequence the held reference is released one cycle after the final frame's own release. The next reference frame then starts a new sequence with nothing stored.

Top module: `frame_reorder_ctrl`

## Requirements
- R1: After reset, disp_valid and err_no_ref are 0. The reference write slot is 0, the newer-reference role is on slot 1, and slot 2 is the B slot.
- R2: The picture type is encoded I=0, P=1, B=2. A decode-done with type B gives disp_valid=1 with disp_slot=2 on the next cycle.
- R3: A decode-done for a reference frame, when at least one reference is stored, releases on the next cycle the slot of the most recently written reference.
- R4: The first reference frame after reset, or after an end of sequence, releases nothing.
- R5: wr_slot is 2 when dec_type is B. For a reference type it is the slot that does not hold the newest reference. Reference writes therefore alternate 0, 1, 0, 1, and the alternation continues across sequence boundaries.
- R6: A decode-done with dec_last=1 first gives that frame's normal release, if it has one. On the following cycle it releases the newest stored reference, or releases nothing if no reference is stored. Afterwards no reference counts as stored.
- R7: A B frame decoded while no reference is stored pulses err_no_ref in the same cycle as its release, and the B frame is still released.
- R8: Only the B-versus-reference distinction matters. Types 0, 1 and the unused code 3 all behave as reference frames.
- R9: Any number of consecutive B frames may arrive. Each is released, and the stored references are unchanged by them.
- R10: disp_valid is a one-cycle pulse, raised only in the cycle after a decode-done or in the cycle after a pending end-of-sequence release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_done | input | 1 | One-cycle strobe: a frame has finished decoding |
| dec_type | input | 2 | Picture type of the frame being decoded (I=0, P=1, B=2, 3 treated as reference) |
| dec_last | input | 1 | Qualifies dec_done: this frame ends the sequence |
| wr_slot | output | 2 | Slot the frame of type dec_type must be written into |
| disp_valid | output | 1 | One-cycle display-release strobe |
| disp_slot | output | 2 | Slot index to display, valid with disp_valid |
| err_no_ref | output | 1 | Pulses with the release of a B frame that had no stored reference |

## Verification
The assertions assume that no decode-done strobe arrives in the cycle where an end-of-sequence release is still pending. They also assume that dec_type is held stable from the moment wr_slot is read until the strobe. The stimulus respects both: it sets the type one half-cycle before each strobe and leaves several idle cycles after every strobe. Within that spacing the stimulus covers B frames with and without stored references, long B runs, the unused type code, and every combination of end-of-sequence with reference and B frames.

// File: rtl/frame_reorder_pkg.sv
package frame_reorder_pkg;

  typedef enum logic [1:0] {
    PIC_I   = 2'd0,
    PIC_P   = 2'd1,
    PIC_B   = 2'd2,
    PIC_RSV = 2'd3
  } pic_kind_e;

  // A frame is a reference unless its type is the bidirectional code.
  function automatic logic is_ref_kind(input logic [1:0] kind);
    return kind != PIC_B;
  endfunction

  // Stored-reference count after one decode; saturates at two.
  function automatic logic [1:0] ref_count_after(input logic [1:0] cnt,
                                                 input logic       adds_ref);
    logic [1:0] res;
    if (!adds_ref)        res = cnt;
    else if (cnt == 2'd2) res = 2'd2;
    else                  res = cnt + 2'd1;
    return res;
  endfunction

  // A reference decode releases something only if an earlier one is held.
  function automatic logic has_held_ref(input logic [1:0] cnt);
    return cnt != 2'd0;
  endfunction

endpackage

// File: rtl/frame_reorder_slots.sv
module frame_reorder_slots
  import frame_reorder_pkg::*;
#(
  parameter int SLOT_W   = 2,
  parameter int REF_LO   = 0,
  parameter int REF_HI   = 1,
  parameter int B_SLOT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_commit,
  input  logic              seq_close,
  output logic [SLOT_W-1:0] older_slot,
  output logic [SLOT_W-1:0] newer_slot,
  output logic [1:0]        ref_cnt
);

  localparam logic [SLOT_W-1:0] LO_IDX = REF_LO[SLOT_W-1:0];
  localparam logic [SLOT_W-1:0] HI_IDX = REF_HI[SLOT_W-1:0];
  localparam logic [SLOT_W-1:0] B_IDX  = B_SLOT[SLOT_W-1:0];

  logic [1:0] cnt_next;

  always_comb begin
    cnt_next = ref_count_after(ref_cnt, ref_commit);
    if (seq_close) cnt_next = 2'd0;
  end

  // The new reference lands in the older slot, which then becomes newest.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older_slot <= LO_IDX;
      newer_slot <= HI_IDX;
      ref_cnt    <= 2'd0;
    end else begin
      if (ref_commit) begin
        older_slot <= newer_slot;
        newer_slot <= older_slot;
      end
      ref_cnt <= cnt_next;
    end
  end

  // R5: the two reference roles never share a slot nor touch the B slot
  a_r5_roles_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (older_slot != newer_slot) && (older_slot != B_IDX) && (newer_slot != B_IDX));

  // R9: a decode that is not a reference leaves the roles where they were
  a_r9_b_keeps_roles: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_commit |=> $stable(older_slot) && $stable(newer_slot));

endmodule

// File: rtl/frame_reorder_release.sv
module frame_reorder_release
  import frame_reorder_pkg::*;
#(
  parameter int SLOT_W = 2,
  parameter int B_SLOT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_done,
  input  logic              is_b,
  input  logic              is_last,
  input  logic [1:0]        ref_cnt,
  input  logic [SLOT_W-1:0] older_slot,
  input  logic [SLOT_W-1:0] newer_slot,
  output logic              disp_valid,
  output logic [SLOT_W-1:0] disp_slot,
  output logic              err_no_ref,
  output logic              flush_pend
);

  localparam logic [SLOT_W-1:0] B_IDX = B_SLOT[SLOT_W-1:0];

  logic              release_now;
  logic [SLOT_W-1:0] release_slot;
  logic [1:0]        cnt_after;
  logic              flush_arm;
  logic [SLOT_W-1:0] flush_target;
  logic [SLOT_W-1:0] flush_slot;

  always_comb begin
    release_now  = dec_done && (is_b || has_held_ref(ref_cnt));
    release_slot = is_b ? B_IDX : newer_slot;
    cnt_after    = ref_count_after(ref_cnt, !is_b);
    flush_arm    = dec_done && is_last && (cnt_after != 2'd0);
    // After a reference decode, the newest reference sits in the old slot.
    flush_target = is_b ? newer_slot : older_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_slot  <= '0;
      err_no_ref <= 1'b0;
      flush_pend <= 1'b0;
      flush_slot <= '0;
    end else begin
      disp_valid <= release_now || flush_pend;
      if (release_now)     disp_slot <= release_slot;
      else if (flush_pend) disp_slot <= flush_slot;
      err_no_ref <= dec_done && is_b && (ref_cnt == 2'd0);
      flush_pend <= flush_arm;
      if (flush_arm) flush_slot <= flush_target;
    end
  end

  // R6: the end-of-sequence release needs a free cycle after the last decode
  a_r6_flush_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend |-> !dec_done);

  // R6: a pending end-of-sequence release appears on the next cycle
  a_r6_flush_released: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend |=> disp_valid);

  // R7: the missing-reference flag only accompanies a release
  a_r7_err_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    err_no_ref |-> disp_valid && (disp_slot == B_IDX));

endmodule

// File: rtl/frame_reorder_ctrl.sv
module frame_reorder_ctrl
  import frame_reorder_pkg::*;
#(
  parameter int SLOT_W = 2,
  parameter int REF_LO = 0,
  parameter int REF_HI = 1,
  parameter int B_SLOT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_done,
  input  logic [1:0]        dec_type,
  input  logic              dec_last,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              disp_valid,
  output logic [SLOT_W-1:0] disp_slot,
  output logic              err_no_ref
);

  localparam logic [SLOT_W-1:0] B_IDX = B_SLOT[SLOT_W-1:0];

  // Named internal events, brought out for the assertions.
  logic              frame_is_b;
  logic              ref_commit;
  logic              seq_close;
  logic [SLOT_W-1:0] older_slot;
  logic [SLOT_W-1:0] newer_slot;
  logic [1:0]        ref_cnt;
  logic              flush_pend;

  assign frame_is_b = !is_ref_kind(dec_type);
  assign ref_commit = dec_done && !frame_is_b;
  assign seq_close  = dec_done && dec_last;
  assign wr_slot    = frame_is_b ? B_IDX : older_slot;

  frame_reorder_slots #(
    .SLOT_W (SLOT_W),
    .REF_LO (REF_LO),
    .REF_HI (REF_HI),
    .B_SLOT (B_SLOT)
  ) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_commit (ref_commit),
    .seq_close  (seq_close),
    .older_slot (older_slot),
    .newer_slot (newer_slot),
    .ref_cnt    (ref_cnt)
  );

  frame_reorder_release #(
    .SLOT_W (SLOT_W),
    .B_SLOT (B_SLOT)
  ) u_release (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_done   (dec_done),
    .is_b       (frame_is_b),
    .is_last    (dec_last),
    .ref_cnt    (ref_cnt),
    .older_slot (older_slot),
    .newer_slot (newer_slot),
    .disp_valid (disp_valid),
    .disp_slot  (disp_slot),
    .err_no_ref (err_no_ref),
    .flush_pend (flush_pend)
  );

  // R2: a B decode is shown from the B slot on the next cycle
  a_r2_b_shown: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && frame_is_b |=> disp_valid && (disp_slot == B_IDX));

  // R3: a reference decode with one held shows the previously newest slot
  a_r3_prev_ref_shown: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && !frame_is_b && (ref_cnt != 2'd0) |=>
      disp_valid && (disp_slot == $past(newer_slot)));

  // R4: the first reference of a sequence is held silently
  a_r4_first_ref_silent: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && !frame_is_b && (ref_cnt == 2'd0) |=> !disp_valid);

  // R10: releases only follow a decode or a pending end-of-sequence release
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> $past(dec_done) || $past(flush_pend));

endmodule

// File: tb/tb_frame_reorder_ctrl.sv
module tb_frame_reorder_ctrl;

  typedef struct {
    logic [1:0] slot;
    logic       err;
    string      tag;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_done = 1'b0;
  logic [1:0] dec_type = 2'd0;
  logic       dec_last = 1'b0;
  logic [1:0] wr_slot;
  logic       disp_valid;
  logic [1:0] disp_slot;
  logic       err_no_ref;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_item_t expq[$];

  // Bench reference model: stored count, newest slot, and a running
  // tally of reference writes whose parity gives the next write slot.
  int         mdl_cnt = 0;
  logic [1:0] mdl_newest = 2'd1;
  int         ref_writes = 0;

  always #10 clk = ~clk;  // 50 MHz

  frame_reorder_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_done   (dec_done),
    .dec_type   (dec_type),
    .dec_last   (dec_last),
    .wr_slot    (wr_slot),
    .disp_valid (disp_valid),
    .disp_slot  (disp_slot),
    .err_no_ref (err_no_ref)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] slot, input logic err, input string tag);
    exp_item_t it;
    it.slot = slot;
    it.err  = err;
    it.tag  = tag;
    expq.push_back(it);
  endtask

  // Monitor: every release must match the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R10", "unexpected release slot", int'(disp_slot), -1);
      end else begin
        exp_item_t it;
        it = expq.pop_front();
        check(disp_slot == it.slot, it.tag, "release slot",
              int'(disp_slot), int'(it.slot));
        check(err_no_ref == it.err, it.tag, "missing-reference flag",
              int'(err_no_ref), int'(it.err));
      end
    end else if (rst_n && err_no_ref) begin
      check(1'b0, "R7", "flag without release", 1, 0);
    end
  end

  // Driver: one decoded frame, with expectations from the requirements.
  task automatic decode(input logic [1:0] kind, input logic last,
                        input string tag);
    logic       is_b;
    logic [1:0] exp_wr;
    is_b = (kind == 2'd2);
    @(negedge clk);
    dec_type = kind;
    dec_last = last;
    #1;
    exp_wr = is_b ? 2'd2 : logic'(ref_writes % 2) ? 2'd1 : 2'd0;
    check(wr_slot == exp_wr, tag, "write slot (R5)", int'(wr_slot), int'(exp_wr));
    if (is_b) begin
      push(2'd2, mdl_cnt == 0, tag);
    end else begin
      if (mdl_cnt != 0) push(mdl_newest, 1'b0, tag);
      mdl_newest = exp_wr;
      ref_writes++;
      if (mdl_cnt < 2) mdl_cnt++;
    end
    if (last) begin
      if (mdl_cnt != 0) push(mdl_newest, 1'b0, "R6");
      mdl_cnt = 0;
    end
    dec_done = 1'b1;
    @(negedge clk);
    dec_done = 1'b0;
    dec_last = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(expq.size() == 0, tag, "releases still missing", expq.size(), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(disp_valid == 1'b0, "R1", "disp_valid after reset", int'(disp_valid), 0);
    check(err_no_ref == 1'b0, "R1", "err_no_ref after reset", int'(err_no_ref), 0);
    dec_type = 2'd0; #1;
    check(wr_slot == 2'd0, "R1", "reference write slot", int'(wr_slot), 0);
    dec_type = 2'd2; #1;
    check(wr_slot == 2'd2, "R1", "B write slot", int'(wr_slot), 2);

    // R7: B with nothing stored, still shown
    decode(2'd2, 1'b0, "R7");
    // R4: first reference silent
    decode(2'd0, 1'b0, "R4");
    // R3: next reference releases the previous one
    decode(2'd1, 1'b0, "R3");
    // R2 / R9: a run of B frames
    for (int i = 0; i < 5; i++) decode(2'd2, 1'b0, "R2");
    decode(2'd1, 1'b0, "R3");
    // R8: intra and the unused code act as references
    decode(2'd0, 1'b0, "R8");
    decode(2'd3, 1'b0, "R8");
    // R6: sequence ends on a B frame
    decode(2'd2, 1'b1, "R6");
    // R4: new sequence, first reference silent, write alternation continues
    decode(2'd0, 1'b0, "R4");
    // R6: sequence ends on a reference frame
    decode(2'd1, 1'b1, "R6");
    // R6: a lone reference that also ends the sequence
    decode(2'd0, 1'b1, "R6");
    // R6 / R7: lone B ending a sequence, nothing held
    decode(2'd2, 1'b1, "R7");
    // R9: long B run between two references
    decode(2'd0, 1'b0, "R4");
    for (int i = 0; i < 40; i++) decode(2'd2, 1'b0, "R9");
    decode(2'd1, 1'b0, "R9");
    decode(2'd0, 1'b0, "R3");
    decode(2'd2, 1'b1, "R6");
    // R10: quiet line when idle
    repeat (5) @(negedge clk);
    check(disp_valid == 1'b0, "R10", "idle disp_valid", int'(disp_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule